// File: doc/BRIEF.md
# Interrupt Flag Privilege Checker

This block resolves what a clear-interrupt or set-interrupt instruction does to the processor's interrupt state. It receives one instruction at a time, with its operating mode, the current privilege level, the I/O privilege level and the two virtualization enables. From these it picks one of three outcomes: write the real interrupt flag, write the virtual interrupt flag, or raise a general-protection fault. The block holds the real and virtual interrupt flags itself, so each decision sees the result of the one before it. The virtual-interrupt-pending bit comes in as an input.

When a set-interrupt moves the real flag from 0 to 1, the block gives a one-cycle asynchronous-event pulse. It also raises an interrupt-inhibit level that covers the next instruction. The retire strobe of the next instruction drops that level. Fault delivery, the other flags and the interrupt controller are outside this block.

Encodings: `mode_i` 2'b00 is real mode, 2'b01 is protected mode, 2'b10 is virtual-8086 mode, and 2'b11 is handled as real mode. `op_set_i` = 1 selects set-interrupt and 0 selects clear-interrupt. All results are registered. They appear on the outputs in the cycle after the one in which `instr_valid_i` is sampled high.

Top module: `intflag_arbiter`

## Requirements
- R1: After reset, `if_o`, `vif_o`, `fault_o`, `inhibit_o` and `async_evt_o` are all 0.
- R2: In real mode (`mode_i` 00 or 11), set-interrupt writes 1 to `if_o` and clear-interrupt writes 0, with no privilege check and no fault.
- R3: In protected mode (01) with `pvi_en_i`=1, `cpl_i`=3 and `iopl_i`<3, clear-interrupt clears `vif_o` and leaves `if_o` unchanged.
- R4: In that same protected-mode virtual case, set-interrupt sets `vif_o` when `vip_i`=0 and faults when `vip_i`=1.
- R5: In protected mode outside that virtual case, either instruction faults when `cpl_i` > `iopl_i`; otherwise it writes `if_o`.
- R6: In virtual-8086 mode (10) with `iopl_i`=3, either instruction writes `if_o` directly without a fault.
- R7: In virtual-8086 mode with `iopl_i`≠3, clear-interrupt clears `vif_o` when `vme_en_i`=1 and faults when `vme_en_i`=0.
- R8: In virtual-8086 mode with `iopl_i`≠3, set-interrupt sets `vif_o` only when `vip_i`=0 and `vme_en_i`=1; otherwise it faults.
- R9: A faulting instruction leaves both `if_o` and `vif_o` unchanged. `fault_o` is high for exactly the one cycle after it.
- R10: A set-interrupt that takes `if_o` from 0 to 1 pulses `async_evt_o` for one cycle and raises `inhibit_o`. When `if_o` is already 1, neither is asserted.
- R11: `inhibit_o` falls in the cycle after the next `retire_i` strobe. A strobe in the same cycle as the enabling instruction does not clear it.
- R12: A cycle without `instr_valid_i` changes neither flag and raises neither `fault_o` nor `async_evt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | An interrupt-flag instruction is presented this cycle |
| op_set_i | input | 1 | 1 = set-interrupt, 0 = clear-interrupt |
| mode_i | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual-8086, 11 as real |
| cpl_i | input | PRIV_W | Current privilege level |
| iopl_i | input | PRIV_W | I/O privilege level |
| vme_en_i | input | 1 | Virtual-8086 interrupt virtualization enable |
| pvi_en_i | input | 1 | Protected-mode virtual interrupt enable |
| vip_i | input | 1 | Virtual interrupt pending |
| retire_i | input | 1 | Instruction-retire strobe |
| if_o | output | 1 | Real interrupt flag |
| vif_o | output | 1 | Virtual interrupt flag |
| fault_o | output | 1 | General-protection fault pulse |
| inhibit_o | output | 1 | Interrupt inhibit for the following instruction |
| async_evt_o | output | 1 | Asynchronous-event pulse on an IF enable edge |

## Verification
The bound checker tests several properties on every cycle. A fault freezes both flags. Idle cycles change nothing. An event pulse comes only with a real 0-to-1 edge of the flag and with the inhibit raised. A retire strobe with no new enable drops the inhibit. The mode and privilege decision table (R2 to R8) cannot be stated that way, because only the input combination decides which flag moves. Those cases are covered by the bench's directed scenarios and by a randomized sweep. The sweep compares every cycle against a behavioural model that encodes the table separately.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10,
    MODE_ALT  = 2'b11
  } cpu_mode_e;

  typedef enum logic [1:0] {
    ACT_IF    = 2'b00,
    ACT_VIF   = 2'b01,
    ACT_FAULT = 2'b10
  } flag_act_e;

  typedef struct packed {
    flag_act_e act;
    logic      val;
  } flag_dec_t;

endpackage

// File: rtl/ifc_decode.sv
module ifc_decode
  import ifc_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              op_set_i,
  input  logic [1:0]        mode_i,
  input  logic [PRIV_W-1:0] cpl_i,
  input  logic [PRIV_W-1:0] iopl_i,
  input  logic              vme_en_i,
  input  logic              pvi_en_i,
  input  logic              vip_i,
  input  logic              if_cur_i,
  output flag_dec_t         dec_o,
  output logic              virt_pm_o,
  output logic              enable_edge_o
);

  localparam logic [PRIV_W-1:0] PRIV_TOP = {PRIV_W{1'b1}};

  function automatic logic priv_allows(input logic [PRIV_W-1:0] cpl,
                                       input logic [PRIV_W-1:0] iopl);
    return !(cpl > iopl);
  endfunction

  function automatic logic pm_virtual(input logic pvi,
                                      input logic [PRIV_W-1:0] cpl,
                                      input logic [PRIV_W-1:0] iopl);
    return pvi && (cpl == PRIV_TOP) && (iopl < PRIV_TOP);
  endfunction

  function automatic flag_act_e virt_target(input logic is_set,
                                            input logic pending);
    return (is_set && pending) ? ACT_FAULT : ACT_VIF;
  endfunction

  cpu_mode_e mode_w;
  flag_act_e act_w;
  logic      virt_pm_w;

  assign mode_w    = cpu_mode_e'(mode_i);
  assign virt_pm_w = (mode_w == MODE_PROT) && pm_virtual(pvi_en_i, cpl_i, iopl_i);

  always_comb begin
    act_w = ACT_IF;
    unique case (mode_w)
      MODE_PROT: begin
        if (virt_pm_w) begin
          act_w = virt_target(op_set_i, vip_i);
        end else if (priv_allows(cpl_i, iopl_i)) begin
          act_w = ACT_IF;
        end else begin
          act_w = ACT_FAULT;
        end
      end
      MODE_V86: begin
        if (iopl_i == PRIV_TOP) begin
          act_w = ACT_IF;
        end else if (!vme_en_i) begin
          act_w = ACT_FAULT;
        end else begin
          act_w = virt_target(op_set_i, vip_i);
        end
      end
      default: act_w = ACT_IF;
    endcase
  end

  assign dec_o.act     = act_w;
  assign dec_o.val     = op_set_i;
  assign virt_pm_o     = virt_pm_w;
  assign enable_edge_o = (act_w == ACT_IF) && op_set_i && !if_cur_i;

endmodule

// File: rtl/ifc_flag_regs.sv
module ifc_flag_regs
  import ifc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      apply_i,
  input  flag_dec_t dec_i,
  output logic      if_q_o,
  output logic      vif_q_o,
  output logic      fault_q_o
);

  logic if_q, vif_q, fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_q    <= 1'b0;
      vif_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= apply_i && (dec_i.act == ACT_FAULT);
      if (apply_i && dec_i.act == ACT_IF)  if_q  <= dec_i.val;
      if (apply_i && dec_i.act == ACT_VIF) vif_q <= dec_i.val;
    end
  end

  assign if_q_o    = if_q;
  assign vif_q_o   = vif_q;
  assign fault_q_o = fault_q;

endmodule

// File: rtl/ifc_inhibit.sv
module ifc_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_i,
  input  logic retire_i,
  output logic inhibit_o,
  output logic async_o
);

  logic inh_q, evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= trigger_i;
      if (trigger_i)     inh_q <= 1'b1;
      else if (retire_i) inh_q <= 1'b0;
    end
  end

  assign inhibit_o = inh_q;
  assign async_o   = evt_q;

endmodule

// File: rtl/intflag_arbiter.sv
module intflag_arbiter
  import ifc_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid_i,
  input  logic              op_set_i,
  input  logic [1:0]        mode_i,
  input  logic [PRIV_W-1:0] cpl_i,
  input  logic [PRIV_W-1:0] iopl_i,
  input  logic              vme_en_i,
  input  logic              pvi_en_i,
  input  logic              vip_i,
  input  logic              retire_i,
  output logic              if_o,
  output logic              vif_o,
  output logic              fault_o,
  output logic              inhibit_o,
  output logic              async_evt_o
);

  flag_dec_t dec_w;
  logic      virt_pm_w;
  logic      edge_w;
  logic      trig_w;
  logic      if_w;

  ifc_decode #(.PRIV_W(PRIV_W)) decode_i (
    .op_set_i      (op_set_i),
    .mode_i        (mode_i),
    .cpl_i         (cpl_i),
    .iopl_i        (iopl_i),
    .vme_en_i      (vme_en_i),
    .pvi_en_i      (pvi_en_i),
    .vip_i         (vip_i),
    .if_cur_i      (if_w),
    .dec_o         (dec_w),
    .virt_pm_o     (virt_pm_w),
    .enable_edge_o (edge_w)
  );

  assign trig_w = instr_valid_i && edge_w;

  ifc_flag_regs flags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply_i   (instr_valid_i),
    .dec_i     (dec_w),
    .if_q_o    (if_w),
    .vif_q_o   (vif_o),
    .fault_q_o (fault_o)
  );

  ifc_inhibit inhibit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger_i (trig_w),
    .retire_i  (retire_i),
    .inhibit_o (inhibit_o),
    .async_o   (async_evt_o)
  );

  assign if_o = if_w;

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker (
  input logic clk,
  input logic rst_n,
  input logic instr_valid_i,
  input logic retire_i,
  input logic trig_w,
  input logic virt_pm_w,
  input logic if_o,
  input logic vif_o,
  input logic fault_o,
  input logic inhibit_o,
  input logic async_evt_o
);

  assert_fault_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (if_o == $past(if_o)) && (vif_o == $past(vif_o)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> !fault_o && !async_evt_o && $stable(if_o) && $stable(vif_o));

  assert_event_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    async_evt_o |-> if_o && !$past(if_o) && inhibit_o && !fault_o);

  assert_retire_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !trig_w) |=> !inhibit_o);

  assert_virtual_keeps_if_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && virt_pm_w) |=> $stable(if_o));

endmodule

bind intflag_arbiter ifc_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid_i (instr_valid_i),
  .retire_i      (retire_i),
  .trig_w        (trig_w),
  .virt_pm_w     (virt_pm_w),
  .if_o          (if_o),
  .vif_o         (vif_o),
  .fault_o       (fault_o),
  .inhibit_o     (inhibit_o),
  .async_evt_o   (async_evt_o)
);

// File: tb/intflag_arbiter_tb_top.sv
`timescale 1ns/1ps
module intflag_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, op_set = 1'b0, vme = 1'b0, pvi = 1'b0, vip = 1'b0, retire = 1'b0;
  logic [1:0] mode = 2'b00, cpl = 2'b00, iopl = 2'b00;
  logic       if_o, vif_o, fault_o, inhibit_o, async_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_en = 0;
  string tag = "R1";

  // behavioural reference state
  int m_if = 0, m_vif = 0, m_fault = 0, m_evt = 0, m_inh = 0;

  always #5 clk = ~clk;

  intflag_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(valid), .op_set_i(op_set),
    .mode_i(mode), .cpl_i(cpl), .iopl_i(iopl), .vme_en_i(vme), .pvi_en_i(pvi),
    .vip_i(vip), .retire_i(retire), .if_o(if_o), .vif_o(vif_o),
    .fault_o(fault_o), .inhibit_o(inhibit_o), .async_evt_o(async_o)
  );

  // outcome: 0 = real flag, 1 = virtual flag, 2 = fault
  function automatic int outcome(int md, int s, int c, int io, int ve, int pv, int pend);
    if (md == 1) begin
      if (pv == 1 && c == 3 && io != 3) return (s == 1 && pend == 1) ? 2 : 1;
      return (c > io) ? 2 : 0;
    end
    if (md == 2) begin
      if (io == 3) return 0;
      if (s == 0) return ve ? 1 : 2;
      return (ve == 1 && pend == 0) ? 1 : 2;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_if = 0; m_vif = 0; m_fault = 0; m_evt = 0; m_inh = 0;
    end else begin
      int oc;
      int rise;
      rise = 0;
      oc = valid ? outcome(int'(mode), int'(op_set), int'(cpl), int'(iopl),
                           int'(vme), int'(pvi), int'(vip)) : -1;
      m_fault = (oc == 2);
      if (oc == 0) begin
        if (op_set && m_if == 0) rise = 1;
        m_if = op_set;
      end
      if (oc == 1) m_vif = op_set;
      m_evt = rise;
      if (rise) m_inh = 1;
      else if (retire) m_inh = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (int'(if_o) != m_if || int'(vif_o) != m_vif || int'(fault_o) != m_fault ||
          int'(async_o) != m_evt || int'(inhibit_o) != m_inh) begin
        fails++;
        $display("FAIL %s model: actual if=%0d vif=%0d fault=%0d evt=%0d inh=%0d expected %0d %0d %0d %0d %0d",
                 tag, if_o, vif_o, fault_o, async_o, inhibit_o, m_if, m_vif, m_fault, m_evt, m_inh);
      end
    end
  end

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", t, what, act, exp);
    end
  endtask

  task automatic op(input string t, input logic s, input logic [1:0] md, input logic [1:0] c,
                    input logic [1:0] io, input logic ve, input logic pv, input logic pend);
    @(negedge clk);
    tag = t; valid = 1'b1; op_set = s; mode = md; cpl = c; iopl = io;
    vme = ve; pvi = pv; vip = pend; retire = 1'b0;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle_retire(input string t);
    @(negedge clk);
    tag = t; valid = 1'b0; retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "if", if_o, 1'b0);
    chk("R1", "vif", vif_o, 1'b0);
    chk("R1", "fault", fault_o, 1'b0);
    chk("R1", "inhibit", inhibit_o, 1'b0);
    chk("R1", "async", async_o, 1'b0);
    cmp_en = 1;

    // R2 real mode set: enable edge -> R10 pulse and inhibit
    op("R2", 1, 2'b00, 2'd3, 2'd0, 0, 0, 0);
    chk("R2", "if", if_o, 1'b1);
    chk("R10", "async", async_o, 1'b1);
    chk("R10", "inhibit", inhibit_o, 1'b1);
    idle_retire("R11");
    chk("R11", "inhibit", inhibit_o, 1'b0);
    op("R10", 1, 2'b11, 2'd0, 2'd0, 0, 0, 0);
    chk("R10", "async when already set", async_o, 1'b0);
    chk("R10", "inhibit when already set", inhibit_o, 1'b0);
    op("R2", 0, 2'b00, 2'd3, 2'd0, 0, 0, 0);
    chk("R2", "if cleared", if_o, 1'b0);

    // R11 retire in the same cycle as the enable does not clear
    @(negedge clk);
    tag = "R11"; valid = 1; op_set = 1; mode = 2'b00; retire = 1;
    @(negedge clk);
    valid = 0; retire = 0;
    chk("R11", "inhibit kept", inhibit_o, 1'b1);
    idle_retire("R11");
    chk("R11", "inhibit dropped", inhibit_o, 1'b0);

    // R5 protected, privilege check
    op("R5", 0, 2'b01, 2'd3, 2'd0, 0, 0, 0);
    chk("R5", "fault", fault_o, 1'b1);
    chk("R9", "if kept", if_o, 1'b1);
    op("R5", 0, 2'b01, 2'd1, 2'd2, 0, 0, 0);
    chk("R5", "if cleared", if_o, 1'b0);
    chk("R5", "no fault", fault_o, 1'b0);

    // R4/R3 protected virtual path
    op("R4", 1, 2'b01, 2'd3, 2'd1, 0, 1, 0);
    chk("R4", "vif set", vif_o, 1'b1);
    chk("R4", "if untouched", if_o, 1'b0);
    op("R4", 0, 2'b01, 2'd3, 2'd1, 0, 1, 1);
    chk("R3", "vif cleared", vif_o, 1'b0);
    op("R4", 1, 2'b01, 2'd3, 2'd0, 0, 1, 1);
    chk("R4", "fault on pending", fault_o, 1'b1);
    chk("R9", "vif kept", vif_o, 1'b0);

    // R6 v86 iopl 3
    op("R6", 1, 2'b10, 2'd3, 2'd3, 0, 0, 1);
    chk("R6", "if set", if_o, 1'b1);
    chk("R6", "no fault", fault_o, 1'b0);

    // R8/R7 v86 virtual path
    op("R8", 1, 2'b10, 2'd3, 2'd0, 1, 0, 0);
    chk("R8", "vif set", vif_o, 1'b1);
    op("R7", 0, 2'b10, 2'd3, 2'd2, 0, 0, 0);
    chk("R7", "fault without vme", fault_o, 1'b1);
    chk("R9", "vif kept", vif_o, 1'b1);
    op("R7", 0, 2'b10, 2'd3, 2'd2, 1, 0, 1);
    chk("R7", "vif cleared", vif_o, 1'b0);
    chk("R3", "if untouched by virtual clear", if_o, 1'b1);
    op("R8", 1, 2'b10, 2'd0, 2'd1, 0, 0, 0);
    chk("R8", "fault without vme", fault_o, 1'b1);
    op("R8", 1, 2'b10, 2'd0, 2'd1, 1, 0, 1);
    chk("R8", "fault on pending", fault_o, 1'b1);
    chk("R8", "vif unchanged", vif_o, 1'b0);

    // R12 idle cycles with busy inputs
    @(negedge clk);
    tag = "R12"; valid = 0; op_set = 0; mode = 2'b00; vme = 1; pvi = 1;
    repeat (4) @(negedge clk);
    chk("R12", "if unchanged", if_o, 1'b1);
    chk("R12", "no fault", fault_o, 1'b0);

    // randomized sweep against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      tag = "R2-R12 sweep";
      valid  = ($urandom % 4) != 0;
      op_set = $urandom;
      mode   = $urandom;
      cpl    = $urandom;
      iopl   = $urandom;
      vme    = $urandom;
      pvi    = $urandom;
      vip    = $urandom;
      retire = ($urandom % 3) == 0;
    end
    @(negedge clk);
    valid = 0; retire = 0;
    @(negedge clk);
    cmp_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule